// File: doc/BRIEF.md
# Three-Level Gapped Pulse-Enable Generator

This block runs on a 51.84 MHz reference clock and produces, on every reference cycle, one enable bit. Read as the valid pulses of a gapped clock, the enable is the irregular clock a DS3-into-SONET mapper would produce. The block is used as a stimulus source or as a clock-enable driver in front of a desynchroniser model. There is no accumulator. Nested repetition counters replay one exact gap schedule, pattern for pattern.

The schedule has three levels. A minor pattern is a short burst of active cycles that is either followed by one gap cycle or not. A major pattern repeats each minor kind a fixed number of times, in kind order. The super pattern sends a parameter-set number of type-A majors (two by default) and then one type-B major, and restarts with no idle cycle. The composition of type A is set by parameters and is checked at elaboration. The composition of type B is fixed. Single-cycle start markers show the first cycle of every minor, major and super pattern.

Top module: `gapclk_gen`

## Requirements
- R1: While `rst` is high, and in the cycle in which it is released, the outputs show the first cycle of the schedule: `pulse_en_o`, `minor_sof_o`, `major_sof_o` and `super_sof_o` are all 1.
- R2: Minor kind 1 lasts 8 cycles: enable high for 7 cycles, then 1 gap cycle with enable low.
- R3: Minor kind 2 lasts 6 cycles: enable high for 5 cycles, then 1 gap cycle.
- R4: Minor kind 3 lasts 6 cycles, all with enable high, and has no gap.
- R5: A type-B major is kind 1 sent 63 times, then kind 2 sent 35 times, then kind 3 sent once. It contains exactly 622 enable cycles in exactly 720 reference cycles.
- R6: A type-A major is kind 1 sent `A_REP_P1` times, then kind 2 sent `A_REP_P2` times, then kind 3 sent `A_REP_P3` times. The defaults are 69, 28 and 1, which give 629 enable cycles in 726 cycles. Each count must be at least 1. The pulse and period totals of A are checked at elaboration.
- R7: The super pattern is `NUM_A` type-A majors followed by one type-B major, repeated with no idle cycles. With the defaults, one super pattern spans 2172 cycles and contains 1880 enable cycles.
- R8: `minor_sof_o` is high exactly on the first cycle of each minor pattern. The number of minor markers in a major equals that major's repetition total.
- R9: `major_sof_o` is high exactly on the first cycle of each major pattern, and it is only ever high together with `minor_sof_o`.
- R10: `super_sof_o` is high exactly on the first cycle of the first type-A major of each super pattern, and it is only ever high together with `major_sof_o`.
- R11: The enable is a registered output, defined on every cycle, and the block never stalls. Every cycle with enable low is the last cycle of a minor pattern, so it is followed at once by `minor_sof_o`.
- R12: A reset asserted in the middle of a run returns the outputs to the first cycle of the schedule on the next clock edge. After release, the sequence replays from that point: a kind-1 minor comes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 51.84 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_en_o | output | 1 | Gapped pulse enable, one bit per reference cycle |
| minor_sof_o | output | 1 | Strobe on the first cycle of each minor pattern |
| major_sof_o | output | 1 | Strobe on the first cycle of each major pattern |
| super_sof_o | output | 1 | Strobe on the first cycle of each super pattern |

## Verification
All four outputs come from one register stage that is loaded from the next-state value. What the ports show therefore always belongs to the current position of the sequence, with no extra delay. A reset takes effect at the first rising edge that sees it. The cycle in which reset is dropped still shows schedule cycle zero, and each later edge moves exactly one cycle forward. The bench changes its inputs and samples the outputs at falling edges, and it counts edges from the release sample. This lets it place each expected gap, marker and pattern boundary on an exact cycle index. Pattern totals are measured from one major marker to the next.

// File: rtl/gapclk_pkg.sv
package gapclk_pkg;

    typedef enum logic [1:0] {
        MIN_P1 = 2'd0,
        MIN_P2 = 2'd1,
        MIN_P3 = 2'd2
    } minor_e;

    localparam int unsigned POS_W = 3;
    typedef logic [POS_W-1:0] pos_t;

    localparam int unsigned B_REP_P1  = 63;
    localparam int unsigned B_REP_P2  = 35;
    localparam int unsigned B_REP_P3  = 1;
    localparam int unsigned B_PULSES  = 622;
    localparam int unsigned B_CYCLES  = 720;

    typedef struct packed {
        logic en;
        logic minor_start;
        logic major_start;
        logic super_start;
    } gap_out_t;

    function automatic pos_t minor_last_pos(minor_e m);
        case (m)
            MIN_P1:  return pos_t'(7);
            MIN_P2:  return pos_t'(5);
            default: return pos_t'(5);
        endcase
    endfunction

    function automatic pos_t minor_last_pulse(minor_e m);
        case (m)
            MIN_P1:  return pos_t'(6);
            MIN_P2:  return pos_t'(4);
            default: return pos_t'(5);
        endcase
    endfunction

    function automatic minor_e minor_next(minor_e m);
        case (m)
            MIN_P1:  return MIN_P2;
            MIN_P2:  return MIN_P3;
            default: return MIN_P1;
        endcase
    endfunction

    function automatic int unsigned major_pulses(int unsigned r1, int unsigned r2, int unsigned r3);
        return r1 * 7 + r2 * 5 + r3 * 6;
    endfunction

    function automatic int unsigned major_cycles(int unsigned r1, int unsigned r2, int unsigned r3);
        return r1 * 8 + r2 * 6 + r3 * 6;
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/gapclk_minor_step.sv
module gapclk_minor_step
    import gapclk_pkg::*;
(
    input  pos_t   pos,
    input  minor_e kind,
    output logic   last_cycle,
    output logic   pulse
);

    always_comb begin
        last_cycle = (pos == minor_last_pos(kind));
        pulse      = (pos <= minor_last_pulse(kind));
    end

endmodule

// File: rtl/gapclk_rep_sel.sv
module gapclk_rep_sel
    import gapclk_pkg::*;
#(
    parameter int unsigned A_REP_P1 = 69,
    parameter int unsigned A_REP_P2 = 28,
    parameter int unsigned A_REP_P3 = 1,
    parameter int unsigned REP_W    = 7
) (
    input  logic             in_b,
    input  minor_e           kind,
    output logic [REP_W-1:0] last_rep
);

    localparam logic [REP_W-1:0] A_L1 = REP_W'(A_REP_P1 - 1);
    localparam logic [REP_W-1:0] A_L2 = REP_W'(A_REP_P2 - 1);
    localparam logic [REP_W-1:0] A_L3 = REP_W'(A_REP_P3 - 1);
    localparam logic [REP_W-1:0] B_L1 = REP_W'(B_REP_P1 - 1);
    localparam logic [REP_W-1:0] B_L2 = REP_W'(B_REP_P2 - 1);
    localparam logic [REP_W-1:0] B_L3 = REP_W'(B_REP_P3 - 1);

    always_comb begin
        case (kind)
            MIN_P1:  last_rep = in_b ? B_L1 : A_L1;
            MIN_P2:  last_rep = in_b ? B_L2 : A_L2;
            default: last_rep = in_b ? B_L3 : A_L3;
        endcase
    end

endmodule

// File: rtl/gapclk_seq.sv
module gapclk_seq
    import gapclk_pkg::*;
#(
    parameter int unsigned A_REP_P1 = 69,
    parameter int unsigned A_REP_P2 = 28,
    parameter int unsigned A_REP_P3 = 1,
    parameter int unsigned NUM_A    = 2,
    parameter int unsigned REP_W    = 7,
    parameter int unsigned SLOT_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    output pos_t              pos_n_o,
    output logic [REP_W-1:0]  rep_n_o,
    output minor_e            kind_n_o,
    output logic [SLOT_W-1:0] slot_n_o,
    output logic              in_b_o
);

    localparam logic [SLOT_W-1:0] SLOT_B = SLOT_W'(NUM_A);

    pos_t              pos_q;
    logic [REP_W-1:0]  rep_q;
    minor_e            kind_q;
    logic [SLOT_W-1:0] slot_q;

    logic              in_b;
    logic              pos_last;
    logic              cur_pulse;
    logic [REP_W-1:0]  rep_last;

    assign in_b = (slot_q == SLOT_B);

    gapclk_minor_step u_step (
        .pos        (pos_q),
        .kind       (kind_q),
        .last_cycle (pos_last),
        .pulse      (cur_pulse)
    );

    gapclk_rep_sel #(
        .A_REP_P1 (A_REP_P1),
        .A_REP_P2 (A_REP_P2),
        .A_REP_P3 (A_REP_P3),
        .REP_W    (REP_W)
    ) u_rep (
        .in_b     (in_b),
        .kind     (kind_q),
        .last_rep (rep_last)
    );

    always_comb begin
        pos_n_o  = pos_q + 1'b1;
        rep_n_o  = rep_q;
        kind_n_o = kind_q;
        slot_n_o = slot_q;
        if (pos_last) begin
            pos_n_o = '0;
            if (rep_q == rep_last) begin
                rep_n_o = '0;
                if (kind_q == MIN_P3) begin
                    kind_n_o = MIN_P1;
                    slot_n_o = in_b ? '0 : slot_q + 1'b1;
                end else begin
                    kind_n_o = minor_next(kind_q);
                end
            end else begin
                rep_n_o = rep_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            rep_q  <= '0;
            kind_q <= MIN_P1;
            slot_q <= '0;
        end else begin
            pos_q  <= pos_n_o;
            rep_q  <= rep_n_o;
            kind_q <= kind_n_o;
            slot_q <= slot_n_o;
        end
    end

    assign in_b_o = in_b;

    assert_pos_bound_R11: assert property (@(posedge clk) disable iff (rst)
        pos_q <= minor_last_pos(kind_q))
        else $error("position ran past end of minor pattern");

    assert_rep_bound_R5: assert property (@(posedge clk) disable iff (rst)
        rep_q <= rep_last)
        else $error("repetition count ran past its limit");

    assert_slot_bound_R7: assert property (@(posedge clk) disable iff (rst)
        slot_q <= SLOT_B)
        else $error("major slot ran past type B");

    assert_gap_only_last_R4: assert property (@(posedge clk) disable iff (rst)
        !cur_pulse |-> (pos_last && kind_q != MIN_P3))
        else $error("gap cycle outside the tail of a gapped minor pattern");

endmodule

// File: rtl/gapclk_gen.sv
module gapclk_gen
    import gapclk_pkg::*;
#(
    parameter int unsigned A_REP_P1 = 69,
    parameter int unsigned A_REP_P2 = 28,
    parameter int unsigned A_REP_P3 = 1,
    parameter int unsigned NUM_A    = 2
) (
    input  logic clk,
    input  logic rst,
    output logic pulse_en_o,
    output logic minor_sof_o,
    output logic major_sof_o,
    output logic super_sof_o
);

    localparam int unsigned REP_MAX  = max3(max3(A_REP_P1, A_REP_P2, A_REP_P3),
                                            max3(B_REP_P1, B_REP_P2, B_REP_P3), 1);
    localparam int unsigned REP_W    = $clog2(REP_MAX + 1);
    localparam int unsigned SLOT_W   = $clog2(NUM_A + 1);
    localparam int unsigned A_PULSES = major_pulses(A_REP_P1, A_REP_P2, A_REP_P3);
    localparam int unsigned A_CYCLES = major_cycles(A_REP_P1, A_REP_P2, A_REP_P3);

    if (A_REP_P1 < 1 || A_REP_P2 < 1 || A_REP_P3 < 1) begin : g_bad_a_reps
        $error("type A repetition counts must each be at least one");
    end
    if (NUM_A < 1) begin : g_bad_num_a
        $error("at least one type A major is needed per super pattern");
    end
    if (A_PULSES >= A_CYCLES || A_CYCLES >= 4096) begin : g_bad_a_totals
        $error("type A totals out of range");
    end
    if (major_pulses(B_REP_P1, B_REP_P2, B_REP_P3) != B_PULSES ||
        major_cycles(B_REP_P1, B_REP_P2, B_REP_P3) != B_CYCLES) begin : g_bad_b_totals
        $error("type B composition does not give its fixed totals");
    end

    pos_t              pos_n;
    logic [REP_W-1:0]  rep_n;
    minor_e            kind_n;
    logic [SLOT_W-1:0] slot_n;
    logic              in_b;

    gapclk_seq #(
        .A_REP_P1 (A_REP_P1),
        .A_REP_P2 (A_REP_P2),
        .A_REP_P3 (A_REP_P3),
        .NUM_A    (NUM_A),
        .REP_W    (REP_W),
        .SLOT_W   (SLOT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .pos_n_o  (pos_n),
        .rep_n_o  (rep_n),
        .kind_n_o (kind_n),
        .slot_n_o (slot_n),
        .in_b_o   (in_b)
    );

    gap_out_t out_n;
    gap_out_t out_q;

    always_comb begin
        out_n.en          = (pos_n <= minor_last_pulse(kind_n));
        out_n.minor_start = (pos_n == '0);
        out_n.major_start = (pos_n == '0) && (rep_n == '0) && (kind_n == MIN_P1);
        out_n.super_start = out_n.major_start && (slot_n == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '{en: 1'b1, minor_start: 1'b1, major_start: 1'b1, super_start: 1'b1};
        end else begin
            out_q <= out_n;
        end
    end

    assign pulse_en_o  = out_q.en;
    assign minor_sof_o = out_q.minor_start;
    assign major_sof_o = out_q.major_start;
    assign super_sof_o = out_q.super_start;

    logic [11:0] chk_cyc;
    logic [11:0] chk_pul;
    logic        chk_prev_b;
    logic        chk_armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_cyc    <= '0;
            chk_pul    <= '0;
            chk_prev_b <= 1'b0;
            chk_armed  <= 1'b0;
        end else if (major_sof_o) begin
            chk_cyc    <= 12'd1;
            chk_pul    <= {11'd0, pulse_en_o};
            chk_prev_b <= in_b;
            chk_armed  <= 1'b1;
        end else begin
            chk_cyc    <= chk_cyc + 12'd1;
            chk_pul    <= chk_pul + {11'd0, pulse_en_o};
        end
    end

    assert_b_totals_R5: assert property (@(posedge clk) disable iff (rst)
        (chk_armed && major_sof_o && chk_prev_b) |->
            (chk_cyc == 12'(B_CYCLES) && chk_pul == 12'(B_PULSES)))
        else $error("type B major totals wrong");

    assert_gap_then_minor_R11: assert property (@(posedge clk) disable iff (rst)
        !pulse_en_o |=> minor_sof_o)
        else $error("gap not followed by a new minor pattern");

    assert_minor_opens_high_R8: assert property (@(posedge clk) disable iff (rst)
        minor_sof_o |-> pulse_en_o)
        else $error("minor pattern began on a gap cycle");

    assert_major_on_minor_R9: assert property (@(posedge clk) disable iff (rst)
        major_sof_o |-> minor_sof_o)
        else $error("major marker without minor marker");

    assert_super_on_major_R10: assert property (@(posedge clk) disable iff (rst)
        super_sof_o |-> major_sof_o)
        else $error("super marker without major marker");

endmodule

// File: tb/gapclk_gen_tb.sv
module gapclk_gen_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en, msof, jsof, ssof;

    always #4 clk = ~clk;

    gapclk_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .pulse_en_o  (en),
        .minor_sof_o (msof),
        .major_sof_o (jsof),
        .super_sof_o (ssof)
    );

    typedef struct packed {
        logic [7:0]  r1;
        logic [7:0]  r2;
        logic [7:0]  r3;
        logic [11:0] pulses;
        logic [11:0] cycles;
        logic        super_mark;
        logic        is_b;
    } major_vec_t;

    localparam major_vec_t VA_S = '{r1: 8'd69, r2: 8'd28, r3: 8'd1, pulses: 12'd629, cycles: 12'd726, super_mark: 1'b1, is_b: 1'b0};
    localparam major_vec_t VA   = '{r1: 8'd69, r2: 8'd28, r3: 8'd1, pulses: 12'd629, cycles: 12'd726, super_mark: 1'b0, is_b: 1'b0};
    localparam major_vec_t VB   = '{r1: 8'd63, r2: 8'd35, r3: 8'd1, pulses: 12'd622, cycles: 12'd720, super_mark: 1'b0, is_b: 1'b1};
    localparam int NVEC = 9;
    localparam major_vec_t VEC [NVEC] = '{VA_S, VA, VB, VA_S, VA, VB, VA_S, VA, VB};

    int n_checks = 0;
    int n_fail   = 0;
    int wd       = 0;
    bit done     = 1'b0;

    int mcount, mlen, mpul, bad_p1, bad_p2, bad_p3;
    bit low_seen;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic close_minor(input major_vec_t v);
        int idx;
        idx = mcount - 1;
        if (idx < int'(v.r1)) begin
            if (mlen != 8 || mpul != 7) bad_p1++;
        end else if (idx < int'(v.r1) + int'(v.r2)) begin
            if (mlen != 6 || mpul != 5) bad_p2++;
        end else begin
            if (mlen != 6 || mpul != 6) bad_p3++;
        end
    endtask

    task automatic measure(input major_vec_t v, output int cyc, output int pul);
        int bad_mark, bad_gap;
        bit prev_en;
        cyc = 0; pul = 0; mcount = 0; bad_p1 = 0; bad_p2 = 0; bad_p3 = 0;
        bad_mark = 0; bad_gap = 0; prev_en = 1'b1; low_seen = 1'b0; mlen = 0; mpul = 0;
        check(ssof == v.super_mark, "R10 super marker at major start", int'(ssof), int'(v.super_mark));
        do begin
            if (!prev_en && !msof) bad_gap++;
            if (msof && cyc != 0) close_minor(v);
            if (msof) begin
                mlen = 0; mpul = 0; low_seen = 1'b0; mcount++;
            end
            mlen++;
            if (en) begin
                mpul++;
                if (low_seen) mpul += 100;
            end else begin
                low_seen = 1'b1;
            end
            if (ssof && !jsof) bad_mark++;
            if (jsof && !msof) bad_mark++;
            prev_en = en;
            cyc++;
            pul += int'(en);
            @(negedge clk);
        end while (!jsof && cyc < 3000);
        close_minor(v);
        if (!prev_en && !msof) bad_gap++;
        if (v.is_b) begin
            check(cyc == 720, "R5 B major cycles", cyc, 720);
            check(pul == 622, "R5 B major pulses", pul, 622);
        end else begin
            check(cyc == int'(v.cycles), "R6 A major cycles", cyc, int'(v.cycles));
            check(pul == int'(v.pulses), "R6 A major pulses", pul, int'(v.pulses));
        end
        check(mcount == int'(v.r1) + int'(v.r2) + int'(v.r3), "R8 minor markers per major",
              mcount, int'(v.r1) + int'(v.r2) + int'(v.r3));
        check(bad_p1 == 0, "R2 kind-1 minor shape", bad_p1, 0);
        check(bad_p2 == 0, "R3 kind-2 minor shape", bad_p2, 0);
        check(bad_p3 == 0, "R4 kind-3 minor shape", bad_p3, 0);
        check(bad_mark == 0, "R9 major/super marker nesting", bad_mark, 0);
        check(bad_gap == 0, "R11 gap followed by minor start", bad_gap, 0);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd == 60000 && !done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int sup_cyc, sup_pul, c, p;
        sup_cyc = 0; sup_pul = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(en && msof && jsof && ssof, "R1 outputs during reset",
              {en, msof, jsof, ssof}, 15);
        rst = 1'b0;
        check(en && msof && jsof && ssof, "R1 outputs on release cycle",
              {en, msof, jsof, ssof}, 15);

        for (int i = 0; i < NVEC; i++) begin
            measure(VEC[i], c, p);
            sup_cyc += c;
            sup_pul += p;
            if (i % 3 == 2) begin
                check(sup_cyc == 2172, "R7 super pattern cycles", sup_cyc, 2172);
                check(sup_pul == 1880, "R7 super pattern pulses", sup_pul, 1880);
                sup_cyc = 0; sup_pul = 0;
            end
        end
        check(ssof == 1'b1, "R7 fourth super starts after third", int'(ssof), 1);

        repeat (100) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(en && msof && jsof && ssof, "R12 mid-run reset returns to cycle zero",
              {en, msof, jsof, ssof}, 15);
        rst = 1'b0;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (k <= 6) begin
                check(en && !msof, "R12 kind-1 burst after reset", {en, msof}, 2);
            end else if (k == 7) begin
                check(!en && !msof, "R2 gap on cycle 7 after reset", {en, msof}, 0);
            end else begin
                check(en && msof && !jsof, "R11 next minor after gap", {en, msof, jsof}, 6);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule